// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns bytes written by a host into an asynchronous serial bit stream. A byte written into the holding register is moved into a shift register. It is then sent on `txd_o` as a frame: one start bit at 0, five to eight data bits with the least significant bit first, an optional parity bit, and a stop period at 1. The character format comes from a 7-bit control input. That input selects the character length, whether parity is used and which kind (odd, even or a fixed value), the stop length, and a forced-low break.

A 16-bit divisor sets how often a bit-rate tick occurs: one tick every `div_i` clocks. Each bit lasts 16 ticks. Pulsing `div_load_i` restarts the divider at once with the new value. The block reports two flags and one event for an interrupt unit. `hold_empty_o` shows the holding register is free. `tx_empty_o` shows nothing is waiting and nothing is being shifted. `hold_empty_evt_o` is a one-clock pulse each time a byte moves from the holding register into the shifter.

Top module: `async_tx`

## Requirements
- R1: While `rst` is high and after it is released with nothing written, `txd_o` is 1, `hold_empty_o` is 1 and `tx_empty_o` is 1.
- R2: A frame is one start bit at 0, then the data bits with the least significant bit first, then the stop period at 1. `ctrl_i[1:0]` sets the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: With `ctrl_i[3]`=1 and `ctrl_i[5]`=0, a parity bit follows the last data bit. It makes the count of ones in the data and parity bits even when `ctrl_i[4]`=1, and odd when `ctrl_i[4]`=0.
- R4: With `ctrl_i[3]`=1 and `ctrl_i[5]`=1, the parity bit is a constant: 0 when `ctrl_i[4]`=1 and 1 when `ctrl_i[4]`=0.
- R5: With `ctrl_i[2]`=0 the stop period lasts 16 ticks. With `ctrl_i[2]`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters.
- R6: A tick occurs once every `div_i` clocks, for any `div_i` from 1 to 65535. A value of 0 acts as 1. Every start, data and parity bit lasts 16 ticks.
- R7: A clock with `div_load_i`=1 restarts the divider from the current `div_i`. No count left over from an earlier, larger divisor delays the next frame.
- R8: A write through `hold_wr_i` clears `hold_empty_o` on the next clock. `hold_empty_o` returns to 1 when the byte moves to the shifter, and `hold_empty_evt_o` pulses for exactly one clock at that point for each byte sent. `tx_empty_o` is 1 only when the holding register is empty and no frame is being shifted.
- R9: After a write to an idle transmitter, the start bit begins between 8 and 24 ticks later.
- R10: If the holding register is full when a stop period ends, the next start bit begins on the following tick, with no idle time in between.
- R11: `ctrl_i[6]`=1 drives `txd_o` to 0 from the next clock on. Frame sequencing goes on unchanged: an 8-bit frame with no parity and one stop bit still ends 160 ticks after its transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 7 | Character format and break control (R2-R5, R11 fields) |
| div_i | input | DIV_W | Clocks per bit-rate tick |
| div_load_i | input | 1 | Restart the divider with `div_i` |
| hold_wr_i | input | 1 | Write `hold_data_i` into the holding register |
| hold_data_i | input | 8 | Byte to send |
| txd_o | output | 1 | Serial output, idle high |
| hold_empty_o | output | 1 | Holding register free |
| tx_empty_o | output | 1 | Holding register and shifter both empty |
| hold_empty_evt_o | output | 1 | One-clock pulse when a byte moves to the shifter |

## Verification
The hardest situation to reach is a frame that follows another with no gap. It only occurs when the next byte is already waiting as the last half-bit of the stop period ends. To get there, the driver waits for each transfer pulse and writes the next byte straight away, well inside the running frame. The monitor then measures the exact clock distance between consecutive start edges and compares it with the length computed from the format. That one measurement checks both the 1, 1.5 and 2 stop lengths and the absence of an idle gap. Break is checked with the monitor turned off: the bench times the empty flag, which shows that sequencing went on behind the forced-low line.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int TX_DATA_W   = 8;   // widest character
  localparam int TX_OVS      = 16;  // ticks per bit
  localparam int TX_HALF     = TX_OVS / 2;
  localparam int TX_SETUP    = 8;   // minimum ticks before a first start bit
  localparam int TX_TCNT_W   = $clog2(TX_OVS);
  localparam int TX_BIT_W    = $clog2(TX_DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ALIGN,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] len;
  } tx_fmt_t;

  function automatic tx_fmt_t decode_fmt(input logic [6:0] ctrl);
    tx_fmt_t f;
    f.len       = ctrl[1:0];
    f.long_stop = ctrl[2];
    f.par_en    = ctrl[3];
    f.even      = ctrl[4];
    f.stick     = ctrl[5];
    return f;
  endfunction

endpackage

// File: rtl/async_tx_baud.sv
module async_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= div_eff - DIV_W'(1);
      tick_q <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_eff - DIV_W'(1);
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - DIV_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R7: a reload suppresses the tick that follows it
  a_r7_load_restart: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !tick_o);

  // R6: with a divisor above one, ticks never come back to back
  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !load_i && $stable(div_i) && div_i > DIV_W'(1)) |=> !tick_o);

endmodule

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);

  logic [DATA_W-1:0] data_q;
  logic              full_q;

  always_ff @(posedge clk) begin
    if (wr_i) data_q <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         full_q <= 1'b0;
    else if (wr_i)   full_q <= 1'b1;
    else if (take_i) full_q <= 1'b0;
  end

  assign data_o = data_q;
  assign full_o = full_q;

  // R8: a write always leaves the register full
  a_r8_write_fills: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> full_o);

  // R8: a transfer without a competing write empties it
  a_r8_take_empties: assert property (@(posedge clk) disable iff (rst)
    (take_i && !wr_i) |=> !full_o);

endmodule

// File: rtl/async_tx_serializer.sv
module async_tx_serializer
  import async_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic [6:0]           ctrl_i,
  input  logic                 hold_full_i,
  input  logic [TX_DATA_W-1:0] hold_data_i,
  output logic                 take_o,
  output logic                 busy_o,
  output logic                 txd_o
);

  localparam logic [TX_TCNT_W-1:0] BIT_LAST   = TX_TCNT_W'(TX_OVS - 1);
  localparam logic [TX_TCNT_W-1:0] HALF_LAST  = TX_TCNT_W'(TX_HALF - 1);
  localparam logic [TX_TCNT_W-1:0] SETUP_LAST = TX_TCNT_W'(TX_SETUP - 1);

  tx_state_e             state_q;
  logic [TX_TCNT_W-1:0]  tcnt_q;
  logic [TX_TCNT_W-1:0]  ph_q;
  logic [TX_BIT_W-1:0]   bit_q;
  logic [2:0]            halves_q;
  logic [TX_DATA_W-1:0]  shift_q;
  tx_fmt_t               fmt_q;
  logic                  par_q;
  logic                  txd_q;

  tx_fmt_t               fmt_in;
  logic [TX_DATA_W-1:0]  masked;
  logic                  par_in;
  logic [TX_BIT_W-1:0]   last_idx;
  logic [2:0]            halves_init;
  logic                  bit_end;
  logic                  half_end;
  logic                  line;

  assign fmt_in   = decode_fmt(ctrl_i);
  assign masked   = hold_data_i & (8'hFF >> (2'd3 - fmt_in.len));
  assign par_in   = fmt_in.stick ? ~fmt_in.even
                                 : (fmt_in.even ? ^masked : ~^masked);
  assign last_idx = TX_BIT_W'(4) + TX_BIT_W'(fmt_q.len);
  assign halves_init = !fmt_q.long_stop ? 3'd2 :
                       (fmt_q.len == 2'd0) ? 3'd3 : 3'd4;
  assign bit_end  = (tcnt_q == BIT_LAST);
  assign half_end = (tcnt_q == HALF_LAST);

  always_comb begin
    take_o = 1'b0;
    if (tick_i && hold_full_i) begin
      case (state_q)
        ST_ALIGN: take_o = (ph_q == BIT_LAST);
        ST_STOP:  take_o = half_end && (halves_q == 3'd1);
        default:  take_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = shift_q[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tcnt_q   <= '0;
      ph_q     <= '0;
      bit_q    <= '0;
      halves_q <= '0;
      shift_q  <= '0;
      fmt_q    <= '0;
      par_q    <= 1'b0;
      txd_q    <= 1'b1;
    end else begin
      txd_q <= ctrl_i[6] ? 1'b0 : line;
      if (tick_i) ph_q <= ph_q + TX_TCNT_W'(1);
      if (take_o) begin
        shift_q <= hold_data_i;
        fmt_q   <= fmt_in;
        par_q   <= par_in;
      end
      case (state_q)
        ST_IDLE: begin
          if (hold_full_i) begin
            state_q <= ST_SETUP;
            tcnt_q  <= '0;
          end
        end
        ST_SETUP: begin
          if (tick_i) begin
            if (tcnt_q == SETUP_LAST) begin
              state_q <= ST_ALIGN;
              tcnt_q  <= '0;
            end else begin
              tcnt_q <= tcnt_q + TX_TCNT_W'(1);
            end
          end
        end
        ST_ALIGN: begin
          if (take_o) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (bit_end) begin
              state_q <= ST_DATA;
              tcnt_q  <= '0;
              bit_q   <= '0;
            end else begin
              tcnt_q <= tcnt_q + TX_TCNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (bit_end) begin
              tcnt_q  <= '0;
              shift_q <= shift_q >> 1;
              if (bit_q == last_idx) begin
                if (fmt_q.par_en) begin
                  state_q <= ST_PAR;
                end else begin
                  state_q  <= ST_STOP;
                  halves_q <= halves_init;
                end
              end else begin
                bit_q <= bit_q + TX_BIT_W'(1);
              end
            end else begin
              tcnt_q <= tcnt_q + TX_TCNT_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            if (bit_end) begin
              state_q  <= ST_STOP;
              tcnt_q   <= '0;
              halves_q <= halves_init;
            end else begin
              tcnt_q <= tcnt_q + TX_TCNT_W'(1);
            end
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (half_end) begin
              tcnt_q <= '0;
              if (halves_q == 3'd1) begin
                state_q <= take_o ? ST_START : ST_IDLE;
              end else begin
                halves_q <= halves_q - 3'd1;
              end
            end else begin
              tcnt_q <= tcnt_q + TX_TCNT_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign txd_o  = txd_q;

  // R11: break forces the line low on the following clock
  a_r11_break_low: assert property (@(posedge clk) disable iff (rst)
    ctrl_i[6] |=> !txd_o);

  // R6: bit sequencing only advances on a tick
  a_r6_state_on_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && state_q != ST_IDLE) |=> $stable(state_q));

  // R2: a start bit is driven low when no break is applied
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && !ctrl_i[6]) |=> !txd_o);

endmodule

// File: rtl/async_tx.sv
module async_tx
  import async_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [6:0]           ctrl_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 div_load_i,
  input  logic                 hold_wr_i,
  input  logic [TX_DATA_W-1:0] hold_data_i,
  output logic                 txd_o,
  output logic                 hold_empty_o,
  output logic                 tx_empty_o,
  output logic                 hold_empty_evt_o
);

  logic                 tick;
  logic                 take;
  logic                 busy;
  logic                 hold_full;
  logic [TX_DATA_W-1:0] hold_data;
  logic                 evt_q;

  async_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_i),
    .load_i (div_load_i),
    .tick_o (tick)
  );

  async_tx_hold #(.DATA_W(TX_DATA_W)) hold_i (
    .clk    (clk),
    .rst    (rst),
    .wr_i   (hold_wr_i),
    .data_i (hold_data_i),
    .take_i (take),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  async_tx_serializer ser_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .ctrl_i      (ctrl_i),
    .hold_full_i (hold_full),
    .hold_data_i (hold_data),
    .take_o      (take),
    .busy_o      (busy),
    .txd_o       (txd_o)
  );

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= take;
  end

  assign hold_empty_evt_o = evt_q;
  assign hold_empty_o     = ~hold_full;
  assign tx_empty_o       = ~hold_full & ~busy;

  // R8: right after a transfer the shifter is busy, so not fully empty
  a_r8_evt_busy: assert property (@(posedge clk) disable iff (rst)
    hold_empty_evt_o |-> !tx_empty_o);

  // R8: the transfer pulse lasts a single clock
  a_r8_evt_single: assert property (@(posedge clk) disable iff (rst)
    hold_empty_evt_o |=> !hold_empty_evt_o);

endmodule

// File: tb/async_tx_tb_top.sv
module async_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  ctrl = '0;
  logic [15:0] div = 16'd1;
  logic        div_load = 1'b0;
  logic        hold_wr = 1'b0;
  logic [7:0]  hold_data = '0;
  logic        txd, hold_empty, tx_empty, evt;

  always #5 clk = ~clk;

  async_tx dut_i (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .div_i(div), .div_load_i(div_load),
    .hold_wr_i(hold_wr), .hold_data_i(hold_data), .txd_o(txd),
    .hold_empty_o(hold_empty), .tx_empty_o(tx_empty), .hold_empty_evt_o(evt)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int written = 0, seen = 0, evt_count = 0;
  bit mon_en = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic [6:0] ctrl;
    int         d;
    bit         b2b;
    int         wr_cyc;
  } item_t;
  item_t q[$];

  always @(negedge clk) if (!rst && evt) evt_count++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nbits(input logic [6:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic logic parity(input logic [7:0] d, input logic [6:0] c);
    logic [7:0] m;
    m = d & (8'hFF >> (3 - int'(c[1:0])));
    if (c[5]) return ~c[4];
    return c[4] ? ^m : ~^m;
  endfunction

  function automatic int frame_len(input logic [6:0] c, input int d);
    int halves;
    halves = !c[2] ? 2 : (c[1:0] == 2'd0 ? 3 : 4);
    return ((1 + nbits(c) + int'(c[3])) * 16 + halves * 8) * d;
  endfunction

  // Monitor: pops the scoreboard on each start edge and checks the frame
  initial begin
    logic prev;
    int last_edge, last_len, edge_c;
    item_t it;
    prev = 1'b1; last_edge = 0; last_len = 0;
    forever begin
      @(negedge clk);
      if (mon_en && prev && !txd) begin
        edge_c = cyc;
        if (q.size() == 0) begin
          check(1'b0, "R2", "unexpected start bit", 0, 1);
        end else begin
          it = q.pop_front();
          seen++;
          if (it.b2b)
            check(edge_c - last_edge == last_len, "R10/R5",
                  "start-to-start distance", edge_c - last_edge, last_len);
          else
            check(edge_c - it.wr_cyc >= 8 * it.d && edge_c - it.wr_cyc <= 26 * it.d,
                  "R9/R7", "write-to-start latency", edge_c - it.wr_cyc, 16 * it.d);
          last_edge = edge_c;
          last_len  = frame_len(it.ctrl, it.d);
          repeat (8 * it.d) @(negedge clk);
          check(txd == 1'b0, "R2", "start bit", int'(txd), 0);
          for (int i = 0; i < nbits(it.ctrl); i++) begin
            repeat (16 * it.d) @(negedge clk);
            check(txd == it.data[i], "R2/R6", "data bit", int'(txd), int'(it.data[i]));
          end
          if (it.ctrl[3]) begin
            repeat (16 * it.d) @(negedge clk);
            if (it.ctrl[5])
              check(txd == parity(it.data, it.ctrl), "R4", "stick parity",
                    int'(txd), int'(parity(it.data, it.ctrl)));
            else
              check(txd == parity(it.data, it.ctrl), "R3", "parity bit",
                    int'(txd), int'(parity(it.data, it.ctrl)));
          end
          repeat (16 * it.d) @(negedge clk);
          check(txd == 1'b1, "R5", "stop level", int'(txd), 1);
        end
      end
      prev = txd;
    end
  end

  task automatic write_byte(input logic [7:0] b, input bit b2b);
    item_t it;
    @(negedge clk);
    it.data = b; it.ctrl = ctrl; it.d = (div == 0) ? 1 : int'(div);
    it.b2b = b2b; it.wr_cyc = cyc;
    if (mon_en) q.push_back(it);
    written++;
    hold_wr = 1'b1; hold_data = b;
    @(negedge clk);
    hold_wr = 1'b0;
    check(hold_empty == 1'b0, "R8", "hold_empty after write", int'(hold_empty), 0);
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    div = 16'(d); div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_empty && q.size() == 0));
    repeat (4) @(negedge clk);
  endtask

  task automatic burst(input logic [6:0] c, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [7:0] b2, input int n);
    ctrl = c;
    write_byte(b0, 1'b0);
    if (n > 1) begin
      do @(negedge clk); while (!hold_empty);
      write_byte(b1, 1'b1);
    end
    if (n > 2) begin
      do @(negedge clk); while (!hold_empty);
      write_byte(b2, 1'b1);
    end
    wait_idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1", "txd in reset", int'(txd), 1);
    check(hold_empty == 1'b1, "R1", "hold_empty in reset", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R1", "tx_empty in reset", int'(tx_empty), 1);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(txd == 1'b1 && tx_empty == 1'b1, "R1", "idle after reset",
          int'({txd, tx_empty}), 3);
    mon_en = 1'b1;

    set_div(1);
    burst(7'b0000011, 8'hA5, 8'h3C, 8'hFF, 3);   // R2 8 data bits, 1 stop
    set_div(2);
    burst(7'b0000000, 8'h15, 8'h0A, 8'h00, 2);   // R2 5 data bits
    burst(7'b0011001, 8'h2D, 8'h13, 8'h00, 2);   // R3 6 bits even
    burst(7'b0001110, 8'h55, 8'h6B, 8'h00, 2);   // R3 7 bits odd, R5 2 stop
    burst(7'b0000111, 8'hC3, 8'h81, 8'h00, 2);   // R5 8 bits 2 stop
    burst(7'b0111011, 8'h01, 8'h7E, 8'h00, 2);   // R4 stick 0
    burst(7'b0101011, 8'h01, 8'hF0, 8'h00, 2);   // R4 stick 1
    set_div(3);
    burst(7'b0000100, 8'h1F, 8'h01, 8'h11, 3);   // R5 1.5 stop, R6 div 3

    // R7: long divisor then immediate reload to a short one
    set_div(65535);
    repeat (10) @(negedge clk);
    set_div(2);
    burst(7'b0000011, 8'h96, 8'h00, 8'h00, 1);

    // R11: break holds the line low while the frame runs unseen
    mon_en = 1'b0;
    @(negedge clk); ctrl = 7'b1000011;
    @(negedge clk);
    check(txd == 1'b0, "R11", "break drives low", int'(txd), 0);
    write_byte(8'h81, 1'b0);
    do @(negedge clk); while (!hold_empty);
    t0 = cyc;
    check(tx_empty == 1'b0, "R11", "busy under break", int'(tx_empty), 0);
    do @(negedge clk); while (!tx_empty);
    check(txd == 1'b0, "R11", "still low under break", int'(txd), 0);
    check(cyc - t0 == 160 * 2, "R11", "frame length under break", cyc - t0, 320);
    ctrl = 7'b0000011;
    @(negedge clk);
    check(txd == 1'b1, "R11", "line released", int'(txd), 1);
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    burst(7'b0000011, 8'h5A, 8'h00, 8'h00, 1);

    repeat (10) @(negedge clk);
    check(evt_count == written, "R8", "transfer pulses", evt_count, written);
    check(seen == written - 1, "R2", "frames observed", seen, written - 1);
    finish_run();
  end

endmodule